// File: doc/BRIEF.md
# Dual-Reload Down-Counter with PWM, Event Counting and Two-Pin Capture

This block is a 16-bit down-counter with two companion 16-bit registers, called A and B. A mode field picks how the block uses them. In PWM mode the counter runs from the clock and alternates between the two registers as reload values. A holds the high time and B holds the low time, and the block toggles the level driven on pin A each time the count passes zero. In event mode the counter steps once for each rising edge seen on pin A, and it reloads from A when it passes zero. In capture mode the counter runs freely. A rising edge on pin A stores the count in A, and a rising edge on pin B stores it in B.

Software reaches the counter, A, B and a control word through a small register port. Writes are synchronous and reads are combinational. Hardware events set pending flags in the control word. Each flag has its own enable, and a global enable gates the single interrupt output. After reset the counter, A and B hold no defined value, so software loads all three before it starts a mode. Both pin inputs pass through a two-flop synchronizer before edge detection.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset the control word (address 3) reads 0, `irq` is low, `pin_a_oe` is low and `pin_a_out` is low.
- R2: Address 0 is the counter, 1 is register A, 2 is register B and 3 is the control word. Control bits are: [2:0] mode, [3] run (or capture underflow flag), [4] pend_a, [5] en_a, [6] pend_b, [7] en_b, [8] gie. A write takes effect at the clock edge, and a read returns the current value.
- R3: Mode code 3'b001 with run=1 selects PWM and decrements once per clock. When the counter is 0, the next step reloads it from B if `pin_a_out` is high, or from A if it is low, and inverts `pin_a_out`. The high phase lasts A+1 cycles and the low phase lasts B+1 cycles. `pin_a_oe` is high only in PWM mode.
- R4: In PWM mode, pend_a is set on every reload from register A.
- R5: Mode code 3'b000 with run=1 selects event mode. The counter decrements on the third clock edge after pin A rises. A high level held on the pin gives one step only. When the counter is 0, the next step reloads it from A and sets pend_a. With run=0, edges on pin A have no effect.
- R6: Mode code 3'b010 selects capture mode, in which the counter decrements every clock whatever bit 3 holds. A rising edge on pin A stores, on the third clock edge after the rise, the count present after the second edge into register A and sets pend_a. Pin B does the same into register B and sets pend_b.
- R7: In capture mode, a step from 0 loads all ones into the counter and sets control bit 3.
- R8: `irq` = gie AND (pend_a·en_a OR pend_b·en_b OR (capture mode · bit 3 · en_a)).
- R9: Software clears a pending flag by writing 0 to it in the control word.
- R10: Mode codes 3'b011 to 3'b111 hold the counter and set no flag, whatever the run bit and pin activity.
- R11: Outside capture mode, edges on pin B change neither the counter nor pend_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pin_a_in | input | 1 | Pin A input level |
| pin_a_out | output | 1 | Pin A output level (PWM) |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_in | input | 1 | Pin B input level |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong reload choice or a bad phase bit shows on `pin_a_out` within one phase: the high or low time comes out with the wrong cycle count, or the level toggles without a zero crossing. Wrong synchronizer depth or wrong edge handling moves a captured value by one count per extra stage, and register A or B shows this as soon as it is read. A wrong flag update appears on `irq` in the same cycle as the flag, and a missing wrap or a counter that keeps moving when it should hold shows on the next read of address 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W = 9;
  typedef logic [2:0] mode_t;
  localparam mode_t MODE_EVENT = 3'b000;
  localparam mode_t MODE_PWM   = 3'b001;
  localparam mode_t MODE_CAPT  = 3'b010;

  // control word, MSB first
  typedef struct packed {
    logic  gie;
    logic  en_b;
    logic  pend_b;
    logic  en_a;
    logic  pend_a;
    logic  run_uf;
    mode_t mode;
  } ctl_t;

  localparam int ADR_CNT = 0;
  localparam int ADR_A   = 1;
  localparam int ADR_B   = 2;
  localparam int ADR_CTL = 3;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [STAGES-1:0][N-1:0] sh_q;
  logic [STAGES-1:0][N-1:0] sh_d;
  logic [N-1:0]             prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= '0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  genvar g;
  for (g = 0; g < N; g++) begin : g_edge
    assign rise[g] = sh_q[STAGES-1][g] & ~prev_q[g];
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_t        mode,
  input  logic         run,
  input  logic         edge_a,
  input  logic         edge_b,
  input  logic         we_cnt,
  input  logic         we_a,
  input  logic         we_b,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rega_q,
  output logic [W-1:0] regb_q,
  output logic         lvl_q,
  output logic         set_pa,
  output logic         set_pb,
  output logic         set_uf
);
  logic         is_pwm, is_evt, is_cap;
  logic         step, wrap;
  logic [W-1:0] cnt_d, rega_d, regb_d;
  logic         lvl_d;
  logic         cnt_en, rega_en, regb_en, lvl_en;
  logic         cap_a, cap_b;

  always_comb begin
    is_pwm = (mode == MODE_PWM);
    is_evt = (mode == MODE_EVENT);
    is_cap = (mode == MODE_CAPT);
    step   = (is_pwm & run) | (is_evt & run & edge_a) | is_cap;
    wrap   = step & (cnt_q == '0);
    cap_a  = is_cap & edge_a;
    cap_b  = is_cap & edge_b;

    cnt_d = cnt_q - 1'b1;
    if (wrap) begin
      if (is_pwm)      cnt_d = lvl_q ? regb_q : rega_q;
      else if (is_evt) cnt_d = rega_q;
      else             cnt_d = '1;
    end
    if (we_cnt) cnt_d = wdata;
    cnt_en = step | we_cnt;

    lvl_d  = ~lvl_q;
    lvl_en = is_pwm & wrap;

    rega_d  = we_a ? wdata : cnt_q;
    rega_en = we_a | cap_a;
    regb_d  = we_b ? wdata : cnt_q;
    regb_en = we_b | cap_b;

    set_pa = (is_pwm & wrap & ~lvl_q) | (is_evt & wrap) | cap_a;
    set_pb = cap_b;
    set_uf = is_cap & wrap;
  end

  // data registers carry no reset: software loads them before use
  always_ff @(posedge clk) begin
    if (cnt_en)  cnt_q  <= cnt_d;
    if (rega_en) rega_q <= rega_d;
    if (regb_en) regb_q <= regb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= 1'b0;
    else if (lvl_en) lvl_q <= lvl_d;
  end
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_ctl,
  input  logic [CTL_W-1:0] wdata,
  input  logic             set_pa,
  input  logic             set_pb,
  input  logic             set_uf,
  output ctl_t             ctl_q,
  output logic             irq
);
  ctl_t ctl_d;
  logic ctl_en;

  always_comb begin
    ctl_d = we_ctl ? ctl_t'(wdata) : ctl_q;
    // hardware events take priority over a clearing write
    if (set_pa) ctl_d.pend_a = 1'b1;
    if (set_pb) ctl_d.pend_b = 1'b1;
    if (set_uf) ctl_d.run_uf = 1'b1;
    ctl_en = we_ctl | set_pa | set_pb | set_uf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign irq = ctl_q.gie & ((ctl_q.pend_a & ctl_q.en_a) |
                            (ctl_q.pend_b & ctl_q.en_b) |
                            ((ctl_q.mode == MODE_CAPT) & ctl_q.run_uf & ctl_q.en_a));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int AW     = 2,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          pin_a_in,
  output logic          pin_a_out,
  output logic          pin_a_oe,
  input  logic          pin_b_in,
  output logic          irq
);
  localparam int NPIN = 2;

  logic [1:0]      rst_pipe;
  logic            rst_q;
  logic [NPIN-1:0] rise;
  logic            edge_a, edge_b;
  logic            we_cnt, we_a, we_b, we_ctl;
  ctl_t            ctl_q;
  logic [W-1:0]    cnt_q, rega_q, regb_q;
  logic            lvl_q, set_pa, set_pb, set_uf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  tmr_sync_edge #(.N(NPIN), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_q),
    .din  ({pin_b_in, pin_a_in}),
    .rise (rise)
  );
  assign edge_a = rise[0];
  assign edge_b = rise[1];

  always_comb begin
    we_cnt = reg_we & (reg_addr == AW'(ADR_CNT));
    we_a   = reg_we & (reg_addr == AW'(ADR_A));
    we_b   = reg_we & (reg_addr == AW'(ADR_B));
    we_ctl = reg_we & (reg_addr == AW'(ADR_CTL));
  end

  tmr_core #(.W(W)) u_core (
    .clk   (clk),
    .rst_n (rst_q),
    .mode  (ctl_q.mode),
    .run   (ctl_q.run_uf),
    .edge_a(edge_a),
    .edge_b(edge_b),
    .we_cnt(we_cnt),
    .we_a  (we_a),
    .we_b  (we_b),
    .wdata (reg_wdata),
    .cnt_q (cnt_q),
    .rega_q(rega_q),
    .regb_q(regb_q),
    .lvl_q (lvl_q),
    .set_pa(set_pa),
    .set_pb(set_pb),
    .set_uf(set_uf)
  );

  tmr_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_q),
    .we_ctl(we_ctl),
    .wdata (reg_wdata[CTL_W-1:0]),
    .set_pa(set_pa),
    .set_pb(set_pb),
    .set_uf(set_uf),
    .ctl_q (ctl_q),
    .irq   (irq)
  );

  always_comb begin
    case (reg_addr)
      AW'(ADR_CNT): reg_rdata = cnt_q;
      AW'(ADR_A):   reg_rdata = rega_q;
      AW'(ADR_B):   reg_rdata = regb_q;
      AW'(ADR_CTL): reg_rdata = W'(ctl_q);
      default:      reg_rdata = '0;
    endcase
  end

  assign pin_a_out = lvl_q;
  assign pin_a_oe  = (ctl_q.mode == MODE_PWM);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input ctl_t         ctl,
  input logic [W-1:0] cnt,
  input logic         lvl,
  input logic         irq,
  input logic         we,
  input logic         we_ctl,
  input logic         edge_a,
  input logic         edge_b
);
  assert_lvl_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> ($past(cnt) == '0 && $past(ctl.mode) == MODE_PWM));

  assert_pa_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.pend_a) |-> ($past(we_ctl) || $past(cnt) == '0 || $past(edge_a)));

  assert_pb_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.pend_b) |-> ($past(we_ctl) || ($past(edge_b) && $past(ctl.mode) == MODE_CAPT)));

  assert_uf_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == MODE_CAPT && cnt == '0 && !we) |=> (cnt == '1 && ctl.run_uf));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl.gie && (ctl.pend_a || ctl.pend_b || ctl.run_uf)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode != MODE_EVENT && ctl.mode != MODE_PWM && ctl.mode != MODE_CAPT && !we)
      |=> $stable(cnt));
endmodule

bind dual_reload_timer tmr_checker #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_q),
  .ctl   (ctl_q),
  .cnt   (cnt_q),
  .lvl   (lvl_q),
  .irq   (irq),
  .we    (reg_we),
  .we_ctl(we_ctl),
  .edge_a(edge_a),
  .edge_b(edge_b)
);

// File: tb/tb_dual_reload_timer.sv
module tb_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pin_a_in = 1'b0;
  logic        pin_a_out, pin_a_oe;
  logic        pin_b_in = 1'b0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  dual_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_a_in(pin_a_in),
    .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe), .pin_b_in(pin_b_in), .irq(irq)
  );

  // {expected pin_a_out, expected counter} after each edge; A=3, B=2
  localparam logic [16:0] PWM_VEC [10] = '{
    {1'b0, 16'd0}, {1'b1, 16'd3}, {1'b1, 16'd2}, {1'b1, 16'd1}, {1'b1, 16'd0},
    {1'b0, 16'd2}, {1'b0, 16'd1}, {1'b0, 16'd0}, {1'b1, 16'd3}, {1'b1, 16'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_a();
    @(negedge clk); pin_a_in = 1'b1;
    repeat (4) @(negedge clk);
    pin_a_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk); pin_b_in = 1'b1;
    repeat (4) @(negedge clk);
    pin_b_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd3, v); check("R1 ctl", v, 16'h0000);
    check("R1 irq", irq, 1'b0);
    check("R1 oe", pin_a_oe, 1'b0);
    check("R1 out", pin_a_out, 1'b0);

    // R2 register port
    wr(2'd1, 16'h1234); rd(2'd1, v); check("R2 regA", v, 16'h1234);
    wr(2'd2, 16'hA5C3); rd(2'd2, v); check("R2 regB", v, 16'hA5C3);
    wr(2'd0, 16'hBEEF); rd(2'd0, v); check("R2 cnt", v, 16'hBEEF);

    // R3 / R4 PWM sequence from the vector table
    wr(2'd1, 16'd3); wr(2'd2, 16'd2); wr(2'd0, 16'd0);
    wr(2'd3, 16'h0129);
    reg_addr = 2'd0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check($sformatf("R3 pwm step %0d", k), {pin_a_out, reg_rdata}, PWM_VEC[k]);
      if (k == 1) check("R4 irq on reload from A", irq, 1'b1);
    end
    check("R3 oe in pwm", pin_a_oe, 1'b1);
    wr(2'd3, 16'h0000);
    check("R3 oe off", pin_a_oe, 1'b0);
    rd(2'd3, v); check("R9 pend cleared", v, 16'h0000);

    // R5 event counting
    wr(2'd0, 16'd2); wr(2'd1, 16'd5); wr(2'd3, 16'h0008);
    pulse_a(); rd(2'd0, v); check("R5 one step", v, 16'd1);
    pulse_a(); rd(2'd0, v); check("R5 second step", v, 16'd0);
    pulse_a(); rd(2'd0, v); check("R5 reload from A", v, 16'd5);
    rd(2'd3, v); check("R5 pend_a", v, 16'h0018);
    // R11 pin B ignored in event mode
    pulse_b(); rd(2'd0, v); check("R11 cnt", v, 16'd5);
    rd(2'd3, v); check("R11 pend_b", v, 16'h0018);
    wr(2'd3, 16'h0000);
    pulse_a(); rd(2'd0, v); check("R5 run=0 ignored", v, 16'd5);

    // R8 gating
    wr(2'd3, 16'h0030); #1 check("R8 gie off", irq, 1'b0);
    wr(2'd3, 16'h0130); #1 check("R8 a path", irq, 1'b1);
    wr(2'd3, 16'h01C0); #1 check("R8 b path", irq, 1'b1);
    wr(2'd3, 16'h0000); #1 check("R9 irq cleared", irq, 1'b0);

    // R10 idle code
    wr(2'd0, 16'd50); wr(2'd3, 16'h000F);
    repeat (5) @(negedge clk);
    pulse_a(); pulse_b();
    rd(2'd0, v); check("R10 hold", v, 16'd50);
    rd(2'd3, v); check("R10 no flag", v, 16'h000F);

    // R6 capture
    wr(2'd3, 16'h0000); wr(2'd0, 16'd100); wr(2'd3, 16'h0002);
    @(negedge clk); pin_a_in = 1'b1;
    repeat (4) @(negedge clk); pin_b_in = 1'b1;
    repeat (4) @(negedge clk); pin_a_in = 1'b0; pin_b_in = 1'b0;
    rd(2'd1, v); check("R6 capture A", v, 16'd98);
    rd(2'd2, v); check("R6 capture B", v, 16'd94);
    rd(2'd3, v); check("R6 flags", v, 16'h0052);

    // R7 underflow wrap
    repeat (4) @(negedge clk);
    wr(2'd0, 16'd3);
    reg_addr = 2'd0;
    repeat (5) @(negedge clk);
    check("R7 wrap value", reg_rdata, 16'hFFFF);
    rd(2'd3, v); check("R7 flag", v, 16'h005A);
    check("R8 uf needs en", irq, 1'b0);
    wr(2'd3, 16'h012A); #1 check("R8 uf path", irq, 1'b1);
    wr(2'd3, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule